// File: doc/BRIEF.md
# Codec Indirect Register Access Port

This block is the byte-wide CPU slave port of a telephony and audio codec. The CPU sees eight direct byte addresses. Behind them sits a larger space of indirect configuration registers. The CPU writes a register number to the command port, then moves that register's bytes through the data port. Registers that are sixteen bits wide are filled and read low byte first. An internal byte pointer steps on each data access and returns to the first byte whenever a new command is written.

The port also holds two other pieces of state. The first is a read-to-clear interrupt status register. The second is a one-byte transmit and receive buffer for the audio B channel. A strobe marks each 8 kHz sample period. On that strobe the block latches the incoming sample byte, presents the queued outgoing byte on its output, and raises the data-transfer interrupt source if that source is enabled. Bit reversal of the channel bytes can be selected per direction. The indirect registers are plain storage for gains, operating mode, mux control and encoding selection. The operating mode and the encoding bit are also brought out as ports.

Top module: `codec_reg_port`

## Requirements
- R1: After reset, every indirect register is zero. The interrupt status, the receive latch and `txByteOut` are zero, `irqOut` is low and `modeSel` is 0.
- R2: A write to offset 1 stores the byte into the register selected by the last write to offset 0. A read of offset 1 returns it. Single-byte registers are 0x21 (init), 0x41 (mux 1), 0x44 (mux 4), 0x69 (mode 1) and 0x6A (mode 2).
- R3: The gain registers 0x63, 0x64, 0x65 and 0x66 are 16 bits wide. The first data write after a command write loads bits 7:0 and the second loads bits 15:8. Data reads return the bytes in the same order, and each command write restarts at the low byte.
- R4: These data accesses have no effect on storage and the listed reads return 0x00: a second or later data write to a single-byte register, a third or later data write to a gain register, a third or later read of a gain register, and a read of an unimplemented register number.
- R5: A read of offset 0 returns the pending bitmask and clears every pending bit on that clock edge. A data-transfer event in the same cycle as the read stays pending.
- R6: `irqOut` is high exactly when some bit is pending, init bits 1:0 equal 1 (active), and init bit 2 (interrupt disable) is clear.
- R7: On `sampleTick`, pending bit 4 (0x10) is set only when mux 4 bit 3 is set.
- R8: On `sampleTick`, `rxByteIn` is latched and can be read at offset 5, and the byte last written to offset 5 appears on `txByteOut`. Between ticks, `txByteOut` holds its value.
- R9: When mux 4 bit 4 is set, the bytes moved on a tick are bit-reversed in both directions. The transmit byte has bit 0 moved to bit 7, and the received byte is reversed the same way.
- R10: `modeSel` follows init bits 1:0, and `aLawSel` follows mode 1 bit 0 (1 means A-law).
- R11: Reads of offsets 2, 3, 4, 6 and 7 return 0x00, and writes to them change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| busAddr | input | 3 | Direct byte offset |
| busWr | input | 1 | Write strobe, one cycle per byte |
| busRd | input | 1 | Read strobe, one cycle per byte |
| busWdata | input | 8 | Write data |
| busRdata | output | 8 | Read data, valid in the cycle of the read strobe |
| sampleTick | input | 1 | One-cycle pulse per sample period |
| rxByteIn | input | 8 | Incoming channel byte, sampled on the tick |
| txByteOut | output | 8 | Outgoing channel byte, updated on the tick |
| irqOut | output | 1 | Gated interrupt request |
| modeSel | output | 2 | Operating mode from the init register |
| aLawSel | output | 1 | Encoding select from mode register 1 |

## Verification
The assertions assume that `busRd` and `busWr` are never high in the same cycle. They also assume that `busRdata` is only meaningful while `busRd` is high, so no property checks it outside a read. The bench drives each bus access as a single one-cycle strobe. Read and write are kept apart in every case. The only overlap the bench creates on purpose is a tick landing in the same cycle as a status read.

// File: rtl/codec_port_pkg.sv
package codec_port_pkg;

  localparam int DATA_W   = 8;
  localparam int ADDR_W   = 3;
  localparam int PTR_W    = 2;
  localparam int GAIN_CNT = 4;
  localparam int GAIN_W   = 2 * DATA_W;

  // direct offsets
  localparam logic [ADDR_W-1:0] OFS_CMD  = 3'd0;
  localparam logic [ADDR_W-1:0] OFS_DATA = 3'd1;
  localparam logic [ADDR_W-1:0] OFS_BB   = 3'd5;

  // indirect register numbers
  localparam logic [DATA_W-1:0] REG_INIT  = 8'h21;
  localparam logic [DATA_W-1:0] REG_MUX1  = 8'h41;
  localparam logic [DATA_W-1:0] REG_MUX4  = 8'h44;
  localparam logic [DATA_W-1:0] REG_GAIN0 = 8'h63;
  localparam logic [DATA_W-1:0] REG_MODE1 = 8'h69;
  localparam logic [DATA_W-1:0] REG_MODE2 = 8'h6A;

  // field positions
  localparam int MUX4_BIRQ_BIT = 3;
  localparam int MUX4_REVB_BIT = 4;
  localparam int INIT_DIS_BIT  = 2;
  localparam int IRQ_BXFER_BIT = 4;
  localparam logic [1:0] MODE_ACTIVE = 2'd1;

  typedef enum logic [1:0] {
    RD_NONE,
    RD_IRQ,
    RD_DATA,
    RD_BB
  } rdSel_e;

  typedef struct packed {
    logic              cmdWr;
    logic              dataWr;
    logic              dataRd;
    logic              irqRd;
    logic              bbWr;
    rdSel_e            rdSel;
    logic [DATA_W-1:0] regSel;
    logic [PTR_W-1:0]  bytePtr;
  } ctrlStrobes_t;

  function automatic logic [DATA_W-1:0] revByte(input logic [DATA_W-1:0] b);
    logic [DATA_W-1:0] r;
    for (int i = 0; i < DATA_W; i++) r[i] = b[DATA_W-1-i];
    return r;
  endfunction

endpackage

// File: rtl/codec_port_ctrl.sv
module codec_port_ctrl
  import codec_port_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic              busWr,
  input  logic              busRd,
  input  logic [DATA_W-1:0] busWdata,
  output ctrlStrobes_t      strb
);

  localparam logic [PTR_W-1:0] PTR_LAST = PTR_W'(2);

  logic [DATA_W-1:0] cmdReg;
  logic [PTR_W-1:0]  bytePtr;
  logic              cmdWr, dataAcc;

  assign cmdWr   = busWr && (busAddr == OFS_CMD);
  assign dataAcc = (busWr || busRd) && (busAddr == OFS_DATA);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cmdReg  <= '0;
      bytePtr <= '0;
    end else if (cmdWr) begin
      cmdReg  <= busWdata;
      bytePtr <= '0;
    end else if (dataAcc && (bytePtr != PTR_LAST)) begin
      bytePtr <= bytePtr + PTR_W'(1);
    end
  end

  always_comb begin
    strb.cmdWr   = cmdWr;
    strb.dataWr  = busWr && (busAddr == OFS_DATA);
    strb.dataRd  = busRd && (busAddr == OFS_DATA);
    strb.irqRd   = busRd && (busAddr == OFS_CMD);
    strb.bbWr    = busWr && (busAddr == OFS_BB);
    strb.regSel  = cmdReg;
    strb.bytePtr = bytePtr;
    case (busAddr)
      OFS_CMD:  strb.rdSel = RD_IRQ;
      OFS_DATA: strb.rdSel = RD_DATA;
      OFS_BB:   strb.rdSel = RD_BB;
      default:  strb.rdSel = RD_NONE;
    endcase
  end

endmodule

// File: rtl/codec_port_regs.sv
module codec_port_regs
  import codec_port_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  ctrlStrobes_t      strb,
  input  logic [DATA_W-1:0] busWdata,
  input  logic              sampleTick,
  input  logic [DATA_W-1:0] rxByteIn,
  output logic [DATA_W-1:0] rdData,
  output logic [DATA_W-1:0] txByteOut,
  output logic              irqOut,
  output logic [1:0]        modeSel,
  output logic              aLawSel
);

  logic [DATA_W-1:0] initReg, mux1Reg, mux4Reg, mode1Reg, mode2Reg;
  logic [GAIN_CNT-1:0][GAIN_W-1:0] gainReg;
  logic [DATA_W-1:0] pendReg, pendSet;
  logic [DATA_W-1:0] txQueue, rxLatch;
  logic [DATA_W-1:0] indRd;
  logic              firstByte, revBb;

  assign firstByte = (strb.bytePtr == '0);
  assign revBb     = mux4Reg[MUX4_REVB_BIT];

  // single-byte indirect registers: only the first data write lands
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      initReg  <= '0;
      mux1Reg  <= '0;
      mux4Reg  <= '0;
      mode1Reg <= '0;
      mode2Reg <= '0;
    end else if (strb.dataWr && firstByte) begin
      case (strb.regSel)
        REG_INIT:  initReg  <= busWdata;
        REG_MUX1:  mux1Reg  <= busWdata;
        REG_MUX4:  mux4Reg  <= busWdata;
        REG_MODE1: mode1Reg <= busWdata;
        REG_MODE2: mode2Reg <= busWdata;
        default: ;
      endcase
    end
  end

  // gain words, low byte then high byte
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      gainReg <= '0;
    end else if (strb.dataWr) begin
      for (int g = 0; g < GAIN_CNT; g++) begin
        if (strb.regSel == REG_GAIN0 + DATA_W'(g)) begin
          if (strb.bytePtr == PTR_W'(0)) gainReg[g][DATA_W-1:0] <= busWdata;
          else if (strb.bytePtr == PTR_W'(1)) gainReg[g][GAIN_W-1:DATA_W] <= busWdata;
        end
      end
    end
  end

  // indirect read mux
  always_comb begin
    indRd = '0;
    case (strb.regSel)
      REG_INIT:  indRd = initReg;
      REG_MUX1:  indRd = mux1Reg;
      REG_MUX4:  indRd = mux4Reg;
      REG_MODE1: indRd = mode1Reg;
      REG_MODE2: indRd = mode2Reg;
      default: begin
        for (int g = 0; g < GAIN_CNT; g++) begin
          if (strb.regSel == REG_GAIN0 + DATA_W'(g)) begin
            if (strb.bytePtr == PTR_W'(0)) indRd = gainReg[g][DATA_W-1:0];
            else if (strb.bytePtr == PTR_W'(1)) indRd = gainReg[g][GAIN_W-1:DATA_W];
          end
        end
      end
    endcase
  end

  // interrupt status: read clears, a same-cycle event survives
  always_comb begin
    pendSet = '0;
    pendSet[IRQ_BXFER_BIT] = sampleTick && mux4Reg[MUX4_BIRQ_BIT];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          pendReg <= '0;
    else if (strb.irqRd) pendReg <= pendSet;
    else                 pendReg <= pendReg | pendSet;
  end

  // B-channel buffer
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      txQueue   <= '0;
      rxLatch   <= '0;
      txByteOut <= '0;
    end else begin
      if (strb.bbWr) txQueue <= busWdata;
      if (sampleTick) begin
        txByteOut <= revBb ? revByte(txQueue) : txQueue;
        rxLatch   <= revBb ? revByte(rxByteIn) : rxByteIn;
      end
    end
  end

  always_comb begin
    case (strb.rdSel)
      RD_IRQ:  rdData = pendReg;
      RD_DATA: rdData = indRd;
      RD_BB:   rdData = rxLatch;
      default: rdData = '0;
    endcase
  end

  assign modeSel = initReg[1:0];
  assign aLawSel = mode1Reg[0];
  assign irqOut  = (|pendReg) && (initReg[1:0] == MODE_ACTIVE) && !initReg[INIT_DIS_BIT];

endmodule

// File: rtl/codec_reg_port.sv
module codec_reg_port
  import codec_port_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic              busWr,
  input  logic              busRd,
  input  logic [DATA_W-1:0] busWdata,
  output logic [DATA_W-1:0] busRdata,
  input  logic              sampleTick,
  input  logic [DATA_W-1:0] rxByteIn,
  output logic [DATA_W-1:0] txByteOut,
  output logic              irqOut,
  output logic [1:0]        modeSel,
  output logic              aLawSel
);

  ctrlStrobes_t strb;

  codec_port_ctrl u_ctrl (
    .clk      (clk),
    .rst_n    (rst_n),
    .busAddr  (busAddr),
    .busWr    (busWr),
    .busRd    (busRd),
    .busWdata (busWdata),
    .strb     (strb)
  );

  codec_port_regs u_regs (
    .clk        (clk),
    .rst_n      (rst_n),
    .strb       (strb),
    .busWdata   (busWdata),
    .sampleTick (sampleTick),
    .rxByteIn   (rxByteIn),
    .rdData     (busRdata),
    .txByteOut  (txByteOut),
    .irqOut     (irqOut),
    .modeSel    (modeSel),
    .aLawSel    (aLawSel)
  );

endmodule

// File: rtl/codec_reg_port_chk.sv
module codec_reg_port_chk (
  input logic       clk,
  input logic       rst_n,
  input logic [2:0] busAddr,
  input logic       busWr,
  input logic       busRd,
  input logic       sampleTick,
  input logic [7:0] txByteOut,
  input logic       irqOut,
  input logic [1:0] modeSel
);

  AST_IRQ_NEEDS_ACTIVE: assert property (@(posedge clk) disable iff (!rst_n)
    irqOut |-> (modeSel == 2'd1)); // R6

  AST_STATUS_READ_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    (busRd && busAddr == 3'd0 && !sampleTick) |=> !irqOut); // R5

  AST_IRQ_QUIET_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    (!busRd && !busWr && !sampleTick) |=> $stable(irqOut)); // R5

  AST_TX_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    !sampleTick |=> $stable(txByteOut)); // R8

  AST_BUS_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
    !(busRd && busWr)); // R2

endmodule

bind codec_reg_port codec_reg_port_chk u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .busAddr    (busAddr),
  .busWr      (busWr),
  .busRd      (busRd),
  .sampleTick (sampleTick),
  .txByteOut  (txByteOut),
  .irqOut     (irqOut),
  .modeSel    (modeSel)
);

// File: tb/sim_codec_reg_port.sv
module sim_codec_reg_port;

  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG   = 20000;

  typedef struct packed {
    logic       isRd;
    logic [2:0] addr;
    logic [7:0] data;   // write data, or expected read data
    logic [7:0] req;
  } vec_t;

  localparam int NVEC = 24;
  localparam vec_t VECS [NVEC] = '{
    // R2 single-byte registers
    '{1'b0, 3'd0, 8'h41, 8'd2}, '{1'b0, 3'd1, 8'h43, 8'd2}, '{1'b1, 3'd1, 8'h43, 8'd2},
    '{1'b0, 3'd0, 8'h6A, 8'd2}, '{1'b0, 3'd1, 8'h03, 8'd2}, '{1'b1, 3'd1, 8'h03, 8'd2},
    // R4 extra write to single-byte register ignored
    '{1'b0, 3'd0, 8'h41, 8'd4}, '{1'b0, 3'd1, 8'h34, 8'd4}, '{1'b0, 3'd1, 8'h77, 8'd4},
    '{1'b1, 3'd1, 8'h34, 8'd4},
    // R3 gain word, low byte first, R4 third write ignored
    '{1'b0, 3'd0, 8'h65, 8'd3}, '{1'b0, 3'd1, 8'hCD, 8'd3}, '{1'b0, 3'd1, 8'hAB, 8'd3},
    '{1'b0, 3'd1, 8'h99, 8'd4}, '{1'b0, 3'd0, 8'h65, 8'd3}, '{1'b1, 3'd1, 8'hCD, 8'd3},
    '{1'b1, 3'd1, 8'hAB, 8'd3}, '{1'b1, 3'd1, 8'h00, 8'd4},
    // R4 unimplemented register
    '{1'b0, 3'd0, 8'h70, 8'd4}, '{1'b0, 3'd1, 8'h5A, 8'd4}, '{1'b1, 3'd1, 8'h00, 8'd4},
    // R11 unused offsets
    '{1'b0, 3'd3, 8'hFF, 8'd11}, '{1'b1, 3'd3, 8'h00, 8'd11}, '{1'b1, 3'd7, 8'h00, 8'd11}
  };

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [2:0] busAddr = '0;
  logic       busWr = 1'b0, busRd = 1'b0;
  logic [7:0] busWdata = '0;
  logic [7:0] busRdata;
  logic       sampleTick = 1'b0;
  logic [7:0] rxByteIn = '0;
  logic [7:0] txByteOut;
  logic       irqOut;
  logic [1:0] modeSel;
  logic       aLawSel;

  int errCnt = 0;
  int chkCnt = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  codec_reg_port u0 (
    .clk(clk), .rst_n(rst_n), .busAddr(busAddr), .busWr(busWr), .busRd(busRd),
    .busWdata(busWdata), .busRdata(busRdata), .sampleTick(sampleTick),
    .rxByteIn(rxByteIn), .txByteOut(txByteOut), .irqOut(irqOut),
    .modeSel(modeSel), .aLawSel(aLawSel)
  );

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
    chkCnt++;
    if (act !== exp) begin
      errCnt++;
      $display("FAIL %s: actual=%02h expected=%02h", req, act, exp);
    end
  endtask

  task automatic wrByte(input logic [2:0] a, input logic [7:0] d);
    @(negedge clk);
    busAddr = a; busWdata = d; busWr = 1'b1;
    @(negedge clk);
    busWr = 1'b0;
  endtask

  task automatic rdByte(input logic [2:0] a, output logic [7:0] d);
    @(negedge clk);
    busAddr = a; busRd = 1'b1;
    #1 d = busRdata;
    @(negedge clk);
    busRd = 1'b0;
  endtask

  task automatic setReg(input logic [7:0] num, input logic [7:0] val);
    wrByte(3'd0, num);
    wrByte(3'd1, val);
  endtask

  task automatic tick(input logic [7:0] rx);
    @(negedge clk);
    sampleTick = 1'b1; rxByteIn = rx;
    @(negedge clk);
    sampleTick = 1'b0;
  endtask

  initial begin
    logic [7:0] rv;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R1 reset state
    check("R1 irqOut", {7'd0, irqOut}, 8'h00);
    check("R1 txByteOut", txByteOut, 8'h00);
    check("R1 modeSel", {6'd0, modeSel}, 8'h00);
    rdByte(3'd0, rv); check("R1 status", rv, 8'h00);
    rdByte(3'd5, rv); check("R1 rx latch", rv, 8'h00);
    wrByte(3'd0, 8'h64);
    rdByte(3'd1, rv); check("R1 gain low", rv, 8'h00);

    // table walk
    for (int i = 0; i < NVEC; i++) begin
      if (VECS[i].isRd) begin
        rdByte(VECS[i].addr, rv);
        check($sformatf("R%0d vec%0d", VECS[i].req, i), rv, VECS[i].data);
      end else begin
        wrByte(VECS[i].addr, VECS[i].data);
      end
    end

    // R10 mode and encoding outputs
    setReg(8'h69, 8'h4F);
    check("R10 aLawSel", {7'd0, aLawSel}, 8'h01);
    setReg(8'h21, 8'h01);
    check("R10 modeSel", {6'd0, modeSel}, 8'h01);

    // R7 tick with source disabled
    tick(8'h00);
    rdByte(3'd0, rv); check("R7 disabled source", rv, 8'h00);

    // R7 R6 enabled source, active mode
    setReg(8'h44, 8'h08);
    tick(8'h00);
    check("R6 irq raised", {7'd0, irqOut}, 8'h01);
    rdByte(3'd0, rv); check("R7 pending bit4", rv, 8'h10);
    check("R5 cleared after read", {7'd0, irqOut}, 8'h00);
    rdByte(3'd0, rv); check("R5 status empty", rv, 8'h00);

    // R6 interrupts disabled via init bit 2
    setReg(8'h21, 8'h05);
    tick(8'h00);
    check("R6 irq gated", {7'd0, irqOut}, 8'h00);
    rdByte(3'd0, rv); check("R6 still pending", rv, 8'h10);

    // R6 data-only mode blocks output
    setReg(8'h21, 8'h02);
    tick(8'h00);
    check("R6 data-only gated", {7'd0, irqOut}, 8'h00);
    rdByte(3'd0, rv); check("R6 pending in data-only", rv, 8'h10);

    // R5 event in the same cycle as the status read
    setReg(8'h21, 8'h01);
    @(negedge clk);
    busAddr = 3'd0; busRd = 1'b1; sampleTick = 1'b1;
    #1 rv = busRdata;
    @(negedge clk);
    busRd = 1'b0; sampleTick = 1'b0;
    check("R5 same-cycle read value", rv, 8'h00);
    check("R5 same-cycle stays pending", {7'd0, irqOut}, 8'h01);
    rdByte(3'd0, rv); check("R5 same-cycle bit", rv, 8'h10);

    // R8 transmit and receive transfer
    wrByte(3'd5, 8'hA5);
    check("R8 tx holds before tick", txByteOut, 8'h00);
    tick(8'h3C);
    check("R8 tx moved", txByteOut, 8'hA5);
    rdByte(3'd5, rv); check("R8 rx latched", rv, 8'h3C);
    wrByte(3'd5, 8'h11);
    repeat (3) @(negedge clk);
    check("R8 tx stable between ticks", txByteOut, 8'hA5);

    // R9 bit reversal
    setReg(8'h44, 8'h18);
    wrByte(3'd5, 8'h01);
    tick(8'h03);
    check("R9 tx reversed", txByteOut, 8'h80);
    rdByte(3'd5, rv); check("R9 rx reversed", rv, 8'hC0);

    done = 1'b1;
  end

  initial begin
    int cyc = 0;
    while (!done && cyc < WATCHDOG) begin
      @(posedge clk);
      cyc++;
    end
    if (!done) begin
      chkCnt++; errCnt++;
      $display("FAIL watchdog: actual=timeout expected=completion");
    end
    $display("Result: errors=%0d of %0d checks", errCnt, chkCnt);
    $finish;
  end

endmodule